// File: doc/BRIEF.md
# Quadrant Muon Road Pattern Matcher

This block classifies the hit pattern of one detector quadrant. Each gap that the trigger uses contributes a 4-bit nibble. Every nibble carries two horizontal-strip bits and two vertical-strip bits. A straight track from the vertex lights one bit of each kind in each gap. The four nibbles form a 16-bit hit address. The block answers one question: does the address contain a road that a vertex track could follow, possibly crossing a lateral boundary once or twice on its way down, after allowing a programmable number of missing hits?

The acceptance function is computed directly in logic. No lookup memory is loaded. Each quadrant uses two instances. One is set for deep penetration, with all four used gaps and two missed hits allowed. The other is set for shallow penetration, with the two top used gaps and one missed hit allowed. The decision is registered, so it appears one clock after the address is presented.

Top module: `quad_road_match`

## Requirements
- R1: `hit_addr[15:12]` is the shallowest used gap and `hit_addr[3:0]` the deepest. Inside a nibble, a track lights one of four codes: 0x5, 0x6, 0x9 or 0xA. A road read in reverse gap order is not the same road, so 0xAAA5 with no misses allowed gives 0.
- R2: A road with the same code in every active gap is accepted when all of its bits are present, for each of the four codes.
- R3: A road may change code once, at any gap boundary, along one of these steps: 5→6, 5→9, 5→A, 6→A, 9→A. Such a road is accepted when all its bits are present (for example 0x5556, 0x66AA, 0x999A).
- R4: A road may change code twice, at any two boundaries, along 5→6→A or 5→9→A (for example 0x566A, 0x59AA).
- R5: No other code change forms a road. Examples are 6↔9, any step back towards 5, and any step out of A. With `miss_allow`=0, 0x6699 gives 0.
- R6: `road_hit` is 1 exactly when some road has at least 2·n − m of its bits present in the active nibbles. Here n is the active nibble count and m is `miss_allow` (0 to 3). For example, 0x6699 at n=4 gives 0 for m=1 and 1 for m=2.
- R7: A bit outside the matched road never prevents acceptance. An all-ones address is always accepted.
- R8: `last_gap` is a physical gap number, and the physical gaps used are 0, 2, 3 and 4. Values 0 and 1 give one active nibble, 2 gives two, 3 gives three, and 4 to 7 give four. Nibbles below the active ones are ignored, so 0x5500 is accepted with `last_gap`=2 and m=1.
- R9: The bit threshold never drops below one. If m ≥ 2·n, one road bit is still needed, and an all-zero address is never accepted.
- R10: `road_hit` is registered. It shows the decision for the inputs present at the previous rising clock edge. A cycle with `rst` high drives it to 0 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_addr | input | 16 | Hit address, four gap nibbles, shallowest in the top nibble |
| last_gap | input | 3 | Physical number of the deepest gap that counts |
| miss_allow | input | 2 | Number of road bits that may be missing |
| road_hit | output | 1 | Registered accept decision |

## Verification
The bench sweeps every address under the deep setting and under the shallow setting. It also sweeps a spread of addresses under all 32 pairs of gap setting and miss allowance. Expected results come from an arithmetic model that builds its own road list from a ranking of the codes.

Directed cases target the errors most likely in this block:
- Forbidding a legal bend would reject 0x566A or 0x59AA.
- Allowing a sideways 6↔9 step would accept 0x6699 with no misses allowed.
- Reversing the nibble order would accept 0xAAA5.
- Failing to mask the deeper nibbles would reject 0x5500 in shallow mode.
- Letting the threshold reach zero would accept an empty address.

// File: rtl/road_pkg.sv
package road_pkg;
  localparam int NIB_W = 4;
  localparam int CODES = 4;

  // Track code for code index 0..3, ordered by lateral rank.
  function automatic logic [NIB_W-1:0] code_val(input int idx);
    case (idx)
      0:       return 4'h5;
      1:       return 4'h6;
      2:       return 4'h9;
      default: return 4'hA;
    endcase
  endfunction

  // Allowed change between consecutive gaps: none, out of 5, or into A.
  function automatic bit step_ok(input int from_i, input int to_i);
    return (from_i == to_i) || (from_i == 0) || (to_i == CODES - 1);
  endfunction

  // Code index that template t places in gap g (gap 0 in the top bits).
  function automatic int tmpl_idx(input int t, input int g, input int gaps);
    return (t >> (2 * (gaps - 1 - g))) & 3;
  endfunction

  function automatic bit road_ok(input int t, input int gaps);
    bit ok = 1'b1;
    for (int g = 1; g < gaps; g++)
      if (!step_ok(tmpl_idx(t, g - 1, gaps), tmpl_idx(t, g, gaps))) ok = 1'b0;
    return ok;
  endfunction
endpackage

// File: rtl/rd_cfg_decode.sv
module rd_cfg_decode #(
  parameter int GAPS   = 4,
  parameter int GSEL_W = 3,
  parameter int MISS_W = 2,
  parameter int NA_W   = $clog2(GAPS + 1),
  parameter int CNT_W  = $clog2(2 * GAPS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [GSEL_W-1:0] last_gap,
  input  logic [MISS_W-1:0] miss_allow,
  output logic [NA_W-1:0]   n_act,
  output logic [CNT_W-1:0]  need
);
  logic [CNT_W-1:0] tot_bits;
  logic [CNT_W-1:0] miss_e;

  // Physical gap 1 is not wired in, so 0 and 1 both leave only the top nibble.
  always_comb begin
    if (int'(last_gap) <= 1)         n_act = NA_W'(1);
    else if (int'(last_gap) >= GAPS) n_act = NA_W'(GAPS);
    else                             n_act = NA_W'(last_gap);
  end

  always_comb begin
    tot_bits = CNT_W'({n_act, 1'b0});
    miss_e   = CNT_W'(miss_allow);
    need     = (miss_e >= tot_bits) ? CNT_W'(1) : tot_bits - miss_e;
  end

  always_ff @(posedge clk) begin
    if (!rst) begin
      // R8
      n_act_range_chk: assert (n_act >= NA_W'(1) && int'(n_act) <= GAPS);
      // R9
      need_floor_chk: assert (need >= CNT_W'(1) && need <= CNT_W'({n_act, 1'b0}));
    end
  end
endmodule

// File: rtl/rd_gap_score.sv
module rd_gap_score
  import road_pkg::*;
#(
  parameter int GAPS   = 4,
  parameter int ADDR_W = GAPS * NIB_W
) (
  input  logic [ADDR_W-1:0]                 hit_addr,
  output logic [GAPS-1:0][CODES-1:0][1:0]   cnt
);
  // For each gap and each track code: how many of its two bits are present.
  for (genvar g = 0; g < GAPS; g++) begin : g_gap
    logic [NIB_W-1:0] nib;
    assign nib = hit_addr[(GAPS-1-g)*NIB_W +: NIB_W];
    for (genvar c = 0; c < CODES; c++) begin : g_code
      localparam logic [NIB_W-1:0] CV = code_val(c);
      logic [NIB_W-1:0] ov;
      assign ov = nib & CV;
      assign cnt[g][c] = {1'b0, ov[0]} + {1'b0, ov[1]} + {1'b0, ov[2]} + {1'b0, ov[3]};
    end
  end
endmodule

// File: rtl/rd_road_eval.sv
module rd_road_eval
  import road_pkg::*;
#(
  parameter int GAPS  = 4,
  parameter int NA_W  = $clog2(GAPS + 1),
  parameter int CNT_W = $clog2(2 * GAPS + 1)
) (
  input  logic [GAPS-1:0][CODES-1:0][1:0] cnt,
  input  logic [NA_W-1:0]                 n_act,
  input  logic [CNT_W-1:0]                need,
  output logic                            accept
);
  localparam int NTMPL = CODES ** GAPS;

  logic [NTMPL-1:0] tmpl_hit;

  for (genvar t = 0; t < NTMPL; t++) begin : g_tmpl
    if (road_ok(t, GAPS)) begin : g_legal
      logic [GAPS-1:0][CNT_W-1:0] part;
      logic [CNT_W-1:0]           score;
      for (genvar g = 0; g < GAPS; g++) begin : g_part
        localparam int CI = tmpl_idx(t, g, GAPS);
        assign part[g] = (NA_W'(g) < n_act) ? CNT_W'(cnt[g][CI]) : '0;
      end
      always_comb begin
        score = '0;
        for (int g = 0; g < GAPS; g++) score = score + part[g];
      end
      assign tmpl_hit[t] = (score >= need);
    end else begin : g_illegal
      assign tmpl_hit[t] = 1'b0;
    end
  end

  assign accept = |tmpl_hit;
endmodule

// File: rtl/quad_road_match.sv
module quad_road_match
  import road_pkg::*;
#(
  parameter int GAPS   = 4,
  parameter int GSEL_W = 3,
  parameter int MISS_W = 2,
  parameter int ADDR_W = GAPS * NIB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] hit_addr,
  input  logic [GSEL_W-1:0] last_gap,
  input  logic [MISS_W-1:0] miss_allow,
  output logic              road_hit
);
  localparam int NA_W  = $clog2(GAPS + 1);
  localparam int CNT_W = $clog2(2 * GAPS + 1);

  logic [NA_W-1:0]                 n_act;
  logic [CNT_W-1:0]                need;
  logic [GAPS-1:0][CODES-1:0][1:0] cnt;
  logic                            accept;

  rd_cfg_decode #(
    .GAPS(GAPS), .GSEL_W(GSEL_W), .MISS_W(MISS_W), .NA_W(NA_W), .CNT_W(CNT_W)
  ) i_cfg (
    .clk(clk), .rst(rst), .last_gap(last_gap), .miss_allow(miss_allow),
    .n_act(n_act), .need(need)
  );

  rd_gap_score #(.GAPS(GAPS), .ADDR_W(ADDR_W)) i_score (
    .hit_addr(hit_addr), .cnt(cnt)
  );

  rd_road_eval #(.GAPS(GAPS), .NA_W(NA_W), .CNT_W(CNT_W)) i_eval (
    .cnt(cnt), .n_act(n_act), .need(need), .accept(accept)
  );

  always_ff @(posedge clk) begin
    if (rst) road_hit <= 1'b0;
    else     road_hit <= accept;
  end

  // R7
  all_hits_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_addr == '1) |=> road_hit);

  // R9
  empty_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_addr == '0) |=> !road_hit);

  // R2
  straight_road_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_addr == {GAPS{4'hA}}) |=> road_hit);

  // R5
  sideways_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_addr == {{(GAPS/2){4'h6}}, {(GAPS-GAPS/2){4'h9}}} && miss_allow == '0
     && int'(last_gap) >= GAPS) |=> !road_hit);
endmodule

// File: tb/test_quad_road_match.sv
module test_quad_road_match;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] hit_addr = '0;
  logic [2:0]  last_gap = '0;
  logic [1:0]  miss_allow = '0;
  logic        road_hit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] roads [$];

  quad_road_match i_quad_road_match (
    .clk(clk), .rst(rst), .hit_addr(hit_addr), .last_gap(last_gap),
    .miss_allow(miss_allow), .road_hit(road_hit)
  );

  always #5 clk = ~clk;

  function automatic logic [3:0] cval(input int i);
    case (i)
      0: return 4'h5;
      1: return 4'h6;
      2: return 4'h9;
      default: return 4'hA;
    endcase
  endfunction

  function automatic int crank(input int i);
    return (i == 0) ? 0 : (i == 3) ? 2 : 1;
  endfunction

  // Roads: each step keeps the code or strictly raises its lateral rank.
  function automatic void build_roads();
    for (int t = 0; t < 256; t++) begin
      int  c [4];
      bit  ok = 1'b1;
      for (int g = 0; g < 4; g++) c[g] = (t >> (6 - 2 * g)) & 3;
      for (int g = 1; g < 4; g++)
        if (!(c[g] == c[g-1] || crank(c[g]) > crank(c[g-1]))) ok = 1'b0;
      if (ok) roads.push_back({cval(c[0]), cval(c[1]), cval(c[2]), cval(c[3])});
    end
  endfunction

  function automatic bit model(input logic [15:0] a, input int lg, input int ms);
    int n    = (lg <= 1) ? 1 : (lg >= 4) ? 4 : lg;
    int need = (2 * n - ms < 1) ? 1 : 2 * n - ms;
    logic [15:0] mask = 16'hFFFF << (16 - 4 * n);
    foreach (roads[i])
      if ($countones(a & roads[i] & mask) >= need) return 1'b1;
    return 1'b0;
  endfunction

  task automatic apply(input logic [15:0] a, input int lg, input int ms,
                       input bit exp, input string req);
    @(negedge clk);
    hit_addr   = a;
    last_gap   = 3'(lg);
    miss_allow = 2'(ms);
    @(posedge clk);
    #1;
    checks++;
    if (road_hit !== exp) begin
      errors++;
      $display("FAIL %s addr=%h gap=%0d miss=%0d actual=%b expected=%b",
               req, a, lg, ms, road_hit, exp);
    end
  endtask

  initial begin
    build_roads();
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (road_hit !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset actual=%b expected=0", road_hit);
    end
    @(negedge clk);
    rst = 1'b0;

    // R1 nibble order
    apply(16'h5AAA, 4, 0, 1'b1, "R1");
    apply(16'hAAA5, 4, 0, 1'b0, "R1");
    // R2 straight roads
    apply(16'h5555, 4, 0, 1'b1, "R2");
    apply(16'h6666, 4, 0, 1'b1, "R2");
    apply(16'h9999, 4, 0, 1'b1, "R2");
    apply(16'hAAAA, 4, 0, 1'b1, "R2");
    // R3 one bend
    apply(16'h5556, 4, 0, 1'b1, "R3");
    apply(16'h66AA, 4, 0, 1'b1, "R3");
    apply(16'h999A, 4, 0, 1'b1, "R3");
    apply(16'h5999, 4, 0, 1'b1, "R3");
    // R4 two bends
    apply(16'h566A, 4, 0, 1'b1, "R4");
    apply(16'h59AA, 4, 0, 1'b1, "R4");
    // R5 illegal steps
    apply(16'h6699, 4, 0, 1'b0, "R5");
    apply(16'hA555, 4, 0, 1'b0, "R5");
    // R6 tolerance
    apply(16'h6699, 4, 1, 1'b0, "R6");
    apply(16'h6699, 4, 2, 1'b1, "R6");
    // R7 extra hits
    apply(16'h5F55, 4, 0, 1'b1, "R7");
    apply(16'hFFFF, 0, 0, 1'b1, "R7");
    // R8 gap mapping and masking
    apply(16'h5500, 2, 1, 1'b1, "R8");
    apply(16'h5500, 4, 2, 1'b0, "R8");
    apply(16'h55F0, 2, 0, 1'b1, "R8");
    apply(16'hA000, 1, 0, 1'b1, "R8");
    apply(16'h5500, 7, 0, 1'b0, "R8");
    apply(16'h5550, 3, 0, 1'b1, "R8");
    // R9 floor of one bit
    apply(16'h0000, 0, 3, 1'b0, "R9");
    apply(16'h1000, 0, 3, 1'b1, "R9");
    apply(16'h4000, 0, 0, 1'b0, "R9");
    // R10 reset clears a pending accept
    @(negedge clk);
    hit_addr = 16'hFFFF;
    rst = 1'b1;
    @(posedge clk);
    #1;
    checks++;
    if (road_hit !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset-clear actual=%b expected=0", road_hit);
    end
    @(negedge clk);
    rst = 1'b0;

    // R6 full sweeps for the deep and shallow settings
    for (int a = 0; a < 65536; a++) apply(16'(a), 4, 2, model(16'(a), 4, 2), "R6");
    for (int a = 0; a < 65536; a++) apply(16'(a), 2, 1, model(16'(a), 2, 1), "R6");
    // R8 spread of addresses over every configuration
    for (int lg = 0; lg < 8; lg++)
      for (int ms = 0; ms < 4; ms++)
        for (int k = 0; k < 512; k++) begin
          logic [15:0] a = 16'((k * 40503 + lg * 977 + ms * 31) & 16'hFFFF);
          apply(a, lg, ms, model(a, lg, ms), "R8");
        end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule